// File: doc/BRIEF.md
# Six-Source Interrupt Poller with Enable Masking

This block collects the interrupt requests of a small 8-bit controller core and turns them into a single vector request for the CPU. There are six sources: two external request pins, three timer overflow sources and one serial port source. An 8-bit enable register, which the CPU reads and writes, holds one enable bit per source and a master bit that silences every source when it is cleared. When several enabled sources are waiting, one fixed order decides which of them is served.

Time is divided into machine cycles of six states with two phases each, so one machine cycle is 12 clocks. The block looks at the requests once per machine cycle, on one fixed slot. When it finds an enabled request, it raises a vector request together with a 3-bit vector index and holds both until the CPU acknowledges. The first two timers deliver overflow pulses late in their machine cycle, so the block applies them only at the cycle boundary. The third timer presents two level flags, and the block looks at them directly at the poll slot. The acknowledge clears the flags that the block owns for the served source. It never clears the third timer's flags.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After synchronous reset the enable register reads 0x00 and `vec_req`, `ext_flag` and `tmr_flag` are all 0.
- R2: A write on `en_wr` stores `en_wdata` in the enable register, and `en_rdata` returns it on the next cycle. Bit 6 is not implemented: it always reads 0 and ignores writes. For example, writing 0xFF reads back 0xBF.
- R3: Enable bit 7 is the master enable. While it is 0, no vector request is raised, whatever else is enabled or pending.
- R4: Enable bit k (k = 0..5) gates the source with vector index k: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R5: When several enabled sources are pending at the same poll, the lowest vector index wins. The order is external 0, timer 0, external 1, timer 1, serial, timer 2.
- R6: The machine cycle has 12 slots, numbered 0..11, and slot 0 is the first clock after reset. Polling happens only on slot 3. `vec_req` rises on the clock that ends slot 3. `vec_req` and `vec_idx` then hold steady until a `vec_ack` cycle, which drops `vec_req` on the following clock.
- R7: A `tmr_ovf[j]` pulse is stored at once. It appears in `tmr_flag[j]` only at the end of slot 11, so it is polled in the next machine cycle and never in the cycle in which it arrived.
- R8: The timer 2 request is the OR of `t2_ovf_flag` and `t2_ext_flag`. A flag that is high on the slot-3 clock is polled in that same machine cycle. An acknowledge has no effect on either flag, so a flag that stays high raises vector 5 again at the next poll.
- R9: Acknowledging vector 1 or 3 clears `tmr_flag[0]` or `tmr_flag[1]`. Acknowledging vector 0 or 2 clears the latched edge flag `ext_flag[0]` or `ext_flag[1]`.
- R10: When `ext_edge_sel[i]` is 1, a rising edge on `ext_pin[i]` sets `ext_flag[i]`, and the request stays until it is acknowledged. When it is 0, the request follows the pin level, nothing is latched, and a pulse that ends before the poll slot is lost.
- R11: A new flag set that lands on the same clock as its acknowledge clear wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| ext_pin | input | 2 | External request pins, active high, already synchronized |
| ext_edge_sel | input | 2 | Per pin: 1 means edge-latched, 0 means level |
| tmr_ovf | input | 2 | One-clock overflow pulses from timers 0 and 1 |
| t2_ovf_flag | input | 1 | Timer 2 overflow flag (level) |
| t2_ext_flag | input | 1 | Timer 2 external flag (level) |
| ser_flag | input | 1 | Serial port request (level) |
| vec_ack | input | 1 | CPU acknowledge of the pending vector |
| vec_req | output | 1 | Vector request to the CPU |
| vec_idx | output | 3 | Index of the requested vector (0..5) |
| ext_flag | output | 2 | Latched edge flags of the external pins |
| tmr_flag | output | 2 | Overflow flags of timers 0 and 1 |

## Verification
Two functions can act on the same clock. The first is the acknowledge clear of a source flag together with a new set of that same flag. The bench provokes this by making a fresh rising edge on external pin 0 in the very cycle it acknowledges vector 0, and it judges the result by reading `ext_flag[0]` and by checking that the vector is raised again at the next poll. The second is a timer overflow pulse that arrives before the poll slot of its machine cycle. The bench places the pulse on slot 1 and confirms that the poll on slot 3 of that cycle stays silent, while the poll of the following cycle delivers the vector. It contrasts this with a timer 2 flag raised on slot 2, which is served by the poll on slot 3 of that same cycle.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;

    localparam int NUM_SRC = 6;
    localparam int VEC_W   = $clog2(NUM_SRC);

    // Vector index doubles as fixed priority rank (lower = served first).
    typedef enum logic [VEC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } irq_src_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] idx;
    } irq_vec_t;

    localparam int EN_W       = 8;
    localparam int GLOBAL_BIT = 7;
    localparam int HOLE_BIT   = 6;

    // Bits of the enable register that hold state.
    function automatic logic [EN_W-1:0] en_impl_mask();
        logic [EN_W-1:0] m;
        m = '1;
        m[HOLE_BIT] = 1'b0;
        return m;
    endfunction

    // Lowest set index among the request bits.
    function automatic irq_vec_t pick_first(input logic [NUM_SRC-1:0] req);
        irq_vec_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                r.valid = 1'b1;
                r.idx   = VEC_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_mc_seq.sv
module irq_mc_seq #(
    parameter int STATES     = 6,
    parameter int PHASES     = 2,
    parameter int POLL_STATE = 1,
    parameter int POLL_PHASE = 1
) (
    input  logic clk,
    input  logic rst,
    output logic poll_tick,
    output logic end_tick
);
    localparam int SW = (STATES > 1) ? $clog2(STATES) : 1;
    localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;

    logic [SW-1:0] state_q;
    logic [PW-1:0] phase_q;
    logic          last_phase;
    logic          last_state;

    assign last_phase = (phase_q == PW'(PHASES - 1));
    assign last_state = (state_q == SW'(STATES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            phase_q <= '0;
        end else if (last_phase) begin
            phase_q <= '0;
            state_q <= last_state ? '0 : state_q + SW'(1);
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign poll_tick = (state_q == SW'(POLL_STATE)) && (phase_q == PW'(POLL_PHASE));
    assign end_tick  = last_state && last_phase;

endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
    parameter int N_EXT = 2,
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             end_tick,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic [N_EXT-1:0] ext_edge_sel,
    input  logic [N_EXT-1:0] ext_clr,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic [N_TMR-1:0] tmr_clr,
    output logic [N_EXT-1:0] ext_req,
    output logic [N_EXT-1:0] ext_flag,
    output logic [N_TMR-1:0] tmr_flag
);

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        logic pin_q;
        logic flag_q;
        logic rise;

        assign rise = ext_pin[i] & ~pin_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q  <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                pin_q <= ext_pin[i];
                if (ext_edge_sel[i])
                    flag_q <= rise | (flag_q & ~ext_clr[i]);
                else
                    flag_q <= 1'b0;
            end
        end

        assign ext_flag[i] = flag_q;
        assign ext_req[i]  = ext_edge_sel[i] ? flag_q : ext_pin[i];
    end

    for (genvar j = 0; j < N_TMR; j++) begin : g_tmr
        logic stage_q;
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= 1'b0;
                flag_q  <= 1'b0;
            end else if (end_tick) begin
                stage_q <= 1'b0;
                flag_q  <= stage_q | tmr_ovf[j] | (flag_q & ~tmr_clr[j]);
            end else begin
                stage_q <= stage_q | tmr_ovf[j];
                flag_q  <= flag_q & ~tmr_clr[j];
            end
        end

        assign tmr_flag[j] = flag_q;
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_poll_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    output irq_vec_t     pick
);
    always_comb pick = pick_first(req);
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
    import irq_poll_pkg::*;
#(
    parameter int MC_STATES  = 6,
    parameter int MC_PHASES  = 2,
    parameter int POLL_STATE = 1,
    parameter int POLL_PHASE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic [EN_W-1:0]  en_wdata,
    output logic [EN_W-1:0]  en_rdata,
    input  logic [1:0]       ext_pin,
    input  logic [1:0]       ext_edge_sel,
    input  logic [1:0]       tmr_ovf,
    input  logic             t2_ovf_flag,
    input  logic             t2_ext_flag,
    input  logic             ser_flag,
    input  logic             vec_ack,
    output logic             vec_req,
    output logic [VEC_W-1:0] vec_idx,
    output logic [1:0]       ext_flag,
    output logic [1:0]       tmr_flag
);
    localparam logic [EN_W-1:0] IMPL = en_impl_mask();

    logic               poll_tick;
    logic               end_tick;
    logic [EN_W-1:0]    en_q;
    logic               glob_en;
    logic [1:0]         ext_req;
    logic [1:0]         ext_clr;
    logic [1:0]         tmr_clr;
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] masked_req;
    irq_vec_t           pick;
    irq_vec_t           vec_q;
    logic               ack_fire;

    irq_mc_seq #(
        .STATES    (MC_STATES),
        .PHASES    (MC_PHASES),
        .POLL_STATE(POLL_STATE),
        .POLL_PHASE(POLL_PHASE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .poll_tick(poll_tick),
        .end_tick (end_tick)
    );

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_wdata & IMPL;
    end

    assign en_rdata = en_q;
    assign glob_en  = en_q[GLOBAL_BIT];

    assign ack_fire = vec_q.valid && vec_ack;
    assign ext_clr[0] = ack_fire && (vec_q.idx == SRC_EXT0);
    assign ext_clr[1] = ack_fire && (vec_q.idx == SRC_EXT1);
    assign tmr_clr[0] = ack_fire && (vec_q.idx == SRC_TMR0);
    assign tmr_clr[1] = ack_fire && (vec_q.idx == SRC_TMR1);

    irq_src_flags #(.N_EXT(2), .N_TMR(2)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .end_tick    (end_tick),
        .ext_pin     (ext_pin),
        .ext_edge_sel(ext_edge_sel),
        .ext_clr     (ext_clr),
        .tmr_ovf     (tmr_ovf),
        .tmr_clr     (tmr_clr),
        .ext_req     (ext_req),
        .ext_flag    (ext_flag),
        .tmr_flag    (tmr_flag)
    );

    always_comb begin
        src_req           = '0;
        src_req[SRC_EXT0] = ext_req[0];
        src_req[SRC_TMR0] = tmr_flag[0];
        src_req[SRC_EXT1] = ext_req[1];
        src_req[SRC_TMR1] = tmr_flag[1];
        src_req[SRC_SER]  = ser_flag;
        src_req[SRC_TMR2] = t2_ovf_flag | t2_ext_flag;
    end

    assign masked_req = src_req & en_q[NUM_SRC-1:0];

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .req (masked_req),
        .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (ack_fire) begin
            vec_q.valid <= 1'b0;
        end else if (!vec_q.valid && poll_tick && glob_en && pick.valid) begin
            vec_q <= pick;
        end
    end

    assign vec_req = vec_q.valid;
    assign vec_idx = vec_q.idx;

endmodule

// File: rtl/irq_poll_chk.sv
module irq_poll_chk (
    input logic       clk,
    input logic       rst,
    input logic       poll_tick,
    input logic       end_tick,
    input logic       glob_en,
    input logic       vec_req,
    input logic       vec_ack,
    input logic [2:0] vec_idx,
    input logic [1:0] tmr_flag
);
    assert_rise_on_poll_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(poll_tick));

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !vec_ack) |=> (vec_req && $stable(vec_idx)));

    assert_master_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(glob_en));

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (vec_idx < 3'd6));

    assert_tmr0_late_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_flag[0]) |-> $past(end_tick));

    assert_tmr1_late_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_flag[1]) |-> $past(end_tick));

    assert_tmr0_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && vec_ack && vec_idx == 3'd1 && !end_tick) |=> !tmr_flag[0]);

    assert_tmr1_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && vec_ack && vec_idx == 3'd3 && !end_tick) |=> !tmr_flag[1]);
endmodule

bind irq_poll_ctrl irq_poll_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .poll_tick(poll_tick),
    .end_tick (end_tick),
    .glob_en  (glob_en),
    .vec_req  (vec_req),
    .vec_ack  (vec_ack),
    .vec_idx  (vec_idx),
    .tmr_flag (tmr_flag)
);

// File: tb/tb_irq_poll_ctrl.sv
module tb_irq_poll_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 12;
    localparam int NTBL       = 9;

    // {enable[7:0], ext_pin[1:0], ser, {t2_ext,t2_ovf}, exp_req, exp_idx[2:0]}
    localparam logic [16:0] TBL [NTBL] = '{
        {8'hBF, 2'b11, 1'b1, 2'b11, 1'b1, 3'd0},
        {8'hBF, 2'b10, 1'b1, 2'b01, 1'b1, 3'd2},
        {8'hBF, 2'b00, 1'b1, 2'b10, 1'b1, 3'd4},
        {8'hBF, 2'b00, 1'b0, 2'b10, 1'b1, 3'd5},
        {8'hA0, 2'b11, 1'b1, 2'b01, 1'b1, 3'd5},
        {8'h3F, 2'b11, 1'b1, 2'b11, 1'b0, 3'd0},
        {8'h80, 2'b11, 1'b1, 2'b11, 1'b0, 3'd0},
        {8'h84, 2'b11, 1'b0, 2'b00, 1'b1, 3'd2},
        {8'h90, 2'b11, 1'b1, 2'b00, 1'b1, 3'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic [7:0] en_rdata;
    logic [1:0] ext_pin = '0;
    logic [1:0] ext_edge_sel = '0;
    logic [1:0] tmr_ovf = '0;
    logic       t2_ovf_flag = 1'b0;
    logic       t2_ext_flag = 1'b0;
    logic       ser_flag = 1'b0;
    logic       vec_ack = 1'b0;
    logic       vec_req;
    logic [2:0] vec_idx;
    logic [1:0] ext_flag;
    logic [1:0] tmr_flag;

    int checks = 0;
    int errors = 0;
    int tb_slot = 0;

    irq_poll_ctrl dut (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .ext_pin(ext_pin), .ext_edge_sel(ext_edge_sel), .tmr_ovf(tmr_ovf),
        .t2_ovf_flag(t2_ovf_flag), .t2_ext_flag(t2_ext_flag), .ser_flag(ser_flag),
        .vec_ack(vec_ack), .vec_req(vec_req), .vec_idx(vec_idx),
        .ext_flag(ext_flag), .tmr_flag(tmr_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Machine-cycle slot as defined by R6: slot 0 is the first clock after reset.
    always @(posedge clk) begin
        if (rst) tb_slot <= 0;
        else     tb_slot <= (tb_slot == SLOTS - 1) ? 0 : tb_slot + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sync_to(input int s);
        do @(negedge clk); while (tb_slot != s);
    endtask

    task automatic write_en(input logic [7:0] v);
        en_wdata = v;
        en_wr    = 1'b1;
        @(negedge clk);
        en_wr    = 1'b0;
    endtask

    task automatic ack_and_quiet();
        ext_pin     = '0;
        ser_flag    = 1'b0;
        t2_ovf_flag = 1'b0;
        t2_ext_flag = 1'b0;
        vec_ack     = 1'b1;
        @(negedge clk);
        vec_ack     = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 en_rdata", en_rdata, 0);
        check("R1 vec_req", vec_req, 0);
        check("R1 ext_flag", ext_flag, 0);
        check("R1 tmr_flag", tmr_flag, 0);

        // R2 read/write, bit 6 hole
        write_en(8'hFF);
        check("R2 readback FF", en_rdata, 8'hBF);
        write_en(8'h00);
        check("R2 readback 00", en_rdata, 8'h00);

        // Table walk: level sources, R3 R4 R5
        for (int i = 0; i < NTBL; i++) begin
            logic [16:0] e;
            e = TBL[i];
            sync_to(5);
            write_en(e[16:9]);
            ext_pin     = e[8:7];
            ser_flag    = e[6];
            t2_ext_flag = e[5];
            t2_ovf_flag = e[4];
            sync_to(4);
            check($sformatf("R3/R4 table %0d vec_req", i), vec_req, e[3]);
            if (e[3]) check($sformatf("R5 table %0d vec_idx", i), vec_idx, e[2:0]);
            ack_and_quiet();
        end

        // R6 poll slot timing and hold
        write_en(8'h90);
        sync_to(0);
        ser_flag = 1'b1;
        sync_to(3);
        check("R6 no req before poll edge", vec_req, 0);
        sync_to(4);
        check("R6 req after poll edge", vec_req, 1);
        check("R6 idx serial", vec_idx, 4);
        write_en(8'hBF);
        ext_pin = 2'b01;
        sync_to(4);
        check("R6 held req", vec_req, 1);
        check("R6 held idx", vec_idx, 4);
        ack_and_quiet();
        check("R6 ack drops req", vec_req, 0);

        // R7 / R9 timer 0 late flag
        write_en(8'h82);
        sync_to(1);
        tmr_ovf = 2'b01;
        @(negedge clk);
        tmr_ovf = 2'b00;
        sync_to(4);
        check("R7 tmr0 not polled same cycle", vec_req, 0);
        check("R7 tmr0 flag not yet visible", tmr_flag[0], 0);
        sync_to(0);
        check("R7 tmr0 flag at cycle boundary", tmr_flag[0], 1);
        sync_to(4);
        check("R7 tmr0 polled next cycle", vec_req, 1);
        check("R7 tmr0 idx", vec_idx, 1);
        ack_and_quiet();
        check("R9 tmr0 flag cleared by ack", tmr_flag[0], 0);

        // Timer 1 pulse late in the cycle
        write_en(8'h88);
        sync_to(8);
        tmr_ovf = 2'b10;
        @(negedge clk);
        tmr_ovf = 2'b00;
        sync_to(4);
        check("R7 tmr1 req", vec_req, 1);
        check("R7 tmr1 idx", vec_idx, 3);
        ack_and_quiet();
        check("R9 tmr1 flag cleared by ack", tmr_flag[1], 0);

        // R8 timer 2 same-cycle poll, not cleared by ack
        write_en(8'hA0);
        sync_to(2);
        t2_ovf_flag = 1'b1;
        sync_to(4);
        check("R8 t2 same-cycle req", vec_req, 1);
        check("R8 t2 idx", vec_idx, 5);
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        sync_to(4);
        check("R8 t2 re-raised after ack", vec_req, 1);
        check("R8 t2 re-raised idx", vec_idx, 5);
        t2_ovf_flag = 1'b0;
        t2_ext_flag = 1'b1;
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        sync_to(4);
        check("R8 t2 ext flag alone", vec_req, 1);
        check("R8 t2 ext idx", vec_idx, 5);
        ack_and_quiet();

        // R10 edge mode latch and R9 clear
        ext_edge_sel = 2'b01;
        write_en(8'h81);
        sync_to(5);
        ext_pin = 2'b01;
        @(negedge clk);
        ext_pin = 2'b00;
        check("R10 edge latched", ext_flag[0], 1);
        sync_to(4);
        check("R10 edge req", vec_req, 1);
        check("R10 edge idx", vec_idx, 0);
        ack_and_quiet();
        check("R9 ext0 flag cleared", ext_flag[0], 0);
        sync_to(4);
        check("R10 edge consumed", vec_req, 0);

        // R10 level mode loses a short pulse
        ext_edge_sel = 2'b00;
        sync_to(5);
        ext_pin = 2'b01;
        @(negedge clk);
        ext_pin = 2'b00;
        sync_to(4);
        check("R10 level pulse lost", vec_req, 0);
        check("R10 level no latch", ext_flag[0], 0);

        // R11 set wins over ack clear
        ext_edge_sel = 2'b01;
        sync_to(5);
        ext_pin = 2'b01;
        @(negedge clk);
        ext_pin = 2'b00;
        sync_to(4);
        check("R11 first req", vec_req, 1);
        @(negedge clk);
        ext_pin = 2'b01;
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        ext_pin = 2'b00;
        check("R11 flag survives ack", ext_flag[0], 1);
        check("R11 req dropped", vec_req, 0);
        sync_to(4);
        check("R11 re-raised", vec_req, 1);
        check("R11 re-raised idx", vec_idx, 0);
        ack_and_quiet();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule